// File: doc/BRIEF.md
# Synchronized Dual-CPU Mailbox Bridge

This block lets a fast main processor hand commands to a much slower slave processor. It also gives both processors a shared data word. Every strobe arriving from either processor is asynchronous to the fabric clock. Each one passes through a two-flop synchronizer and is edge-detected in the single `clk` domain. No strobe ever clocks a register. Because of this, the slave's slow acknowledge handshake is only acted on at its rising edge, and never at its level.

The main processor sees a small register window on an 8-bit bidirectional bus. The window holds a command word, a status word and the shared word. When the main processor writes a command, the ready flag drops at once. Ready rises again only when the slave's acknowledge line rises. The slave raises an interrupt with a falling edge on its interrupt line, and a status read clears it. The slave can also load the shared word by selecting its load address. The slave's serial shift-in path is modelled here as a parallel input.

Register window, as decoded from `m_addr`:

| Address | Register | Read value |
|---------|----------|------------|
| 4'b0000 | command | the command word |
| 4'b1100 | status | bit 1 = interrupt flag, bit 0 = ready flag, other bits 0 |
| 4'b1111 | shared | the shared word |
| any other | none | 0 |

Top module: `mbox_bridge`

## Requirements
- R1: A main-processor write with `m_cs_n` low to address 4'b0000 loads the command register. The load happens when the synchronized write strobe rises. The value appears on `cmd_out`.
- R2: `ready_out` goes low as soon as the start of a qualifying write to address 4'b0000 is detected.
- R3: `ready_out` returns high only on a rising edge of `s_ack`. Holding `s_ack` at either level does nothing. If a command write starts in the same cycle as an acknowledge edge, ready stays low.
- R4: `irq_out` sets on a falling edge of `s_irq_n`. It clears when the main processor starts a read of address 4'b1100 with `m_cs_n` low. If a set and a clear occur in the same cycle, the set wins.
- R5: A main-processor write with `m_cs_n` low to address 4'b1111 loads the shared register.
- R6: A falling edge of `s_cs_n` while `s_addr` is 4'b1011 loads `s_word` into the shared register. If this load and a main-processor write to the shared register are detected in the same cycle, the main-processor write wins.
- R7: The bridge drives `m_dbus` only while a qualified read is active. Otherwise it leaves the bus at high impedance. Reads return the values given in the register window above.
- R8: After reset, `ready_out` is 1 and `irq_out` is 0. The command register and the shared register are both 0.
- R9: Address and write data are captured when the synchronized strobe becomes active. Changes on `m_addr` or `m_dbus` after that point have no effect on the access.
- R10: A write or read strobe while `m_cs_n` is high changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock, much faster than the processor strobes |
| rst | input | 1 | Synchronous active-high reset |
| m_cs_n | input | 1 | Main processor chip select, active low |
| m_rd_n | input | 1 | Main processor read strobe, active low |
| m_wr_n | input | 1 | Main processor write strobe, active low |
| m_addr | input | 4 | Main processor register address |
| m_dbus | inout | 8 | Bidirectional data bus toward the main processor |
| s_cs_n | input | 1 | Slave select, active low |
| s_addr | input | 4 | Slave address |
| s_word | input | 8 | Word shifted in by the slave |
| s_ack | input | 1 | Slave acknowledge; its rising edge marks the slave as ready |
| s_irq_n | input | 1 | Slave interrupt request; its falling edge raises the flag |
| cmd_out | output | 8 | Command word presented to the slave |
| ready_out | output | 1 | Slave ready flag |
| irq_out | output | 1 | Pending slave interrupt |

## Verification
The shared and command registers are driven with random words, written alternately by the main processor and the slave. Each write is read back against a bench model, which shows that both loading sources reach the same storage. The acknowledge is held low and then released. This separates a design that acts on the acknowledge edge from one that follows its level. Directed cases line up the competing events in the same fabric cycle, change the bus in the middle of a strobe, and strobe without chip select. These show the priority choices, the capture at strobe start, and the qualification by chip select. An idle-bus check shows whether the bridge fights another driver.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_CMD    = 4'b0000;
    localparam logic [ADDR_W-1:0] A_STATUS = 4'b1100;
    localparam logic [ADDR_W-1:0] A_SHARED = 4'b1111;
    localparam logic [ADDR_W-1:0] A_SLOAD  = 4'b1011;

    // index of each asynchronous line in the synchronizer bank
    localparam int I_MCS  = 0;
    localparam int I_MRD  = 1;
    localparam int I_MWR  = 2;
    localparam int I_SCS  = 3;
    localparam int I_SACK = 4;
    localparam int I_SIRQ = 5;
    localparam int N_LINES = 6;

    typedef struct packed {
        logic lvl;
        logic rise;
        logic fall;
    } edge_t;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_CMD,
        SEL_STATUS,
        SEL_SHARED
    } sel_e;

    function automatic sel_e decode(input logic [ADDR_W-1:0] a);
        case (a)
            A_CMD:    return SEL_CMD;
            A_STATUS: return SEL_STATUS;
            A_SHARED: return SEL_SHARED;
            default:  return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/mbox_sync_edge.sv
module mbox_sync_edge
    import mbox_pkg::*;
#(
    parameter int   STAGES   = 2,
    parameter logic IDLE_VAL = 1'b1
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  async_in,
    output edge_t ev
);
    logic [STAGES-1:0] chain;
    logic              dly;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= {STAGES{IDLE_VAL}};
            dly   <= IDLE_VAL;
        end else begin
            chain <= {chain[STAGES-2:0], async_in};
            dly   <= chain[STAGES-1];
        end
    end

    assign ev.lvl  = chain[STAGES-1];
    assign ev.rise = chain[STAGES-1] & ~dly;
    assign ev.fall = ~chain[STAGES-1] & dly;

endmodule

// File: rtl/mbox_host_if.sv
module mbox_host_if
    import mbox_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n_s,
    input  edge_t             wr_ev,
    input  edge_t             rd_ev,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic [DATA_W-1:0] cmd_q,
    input  logic [DATA_W-1:0] stat_q,
    input  logic [DATA_W-1:0] shared_q,
    output logic              cmd_start,
    output logic              cmd_commit,
    output logic              sh_commit,
    output logic [DATA_W-1:0] wdata,
    output logic              stat_rd,
    output logic              oe,
    output logic [DATA_W-1:0] rdata
);
    logic              wr_open;
    sel_e              wr_sel;
    logic              wr_go, rd_go;
    sel_e              now_sel;

    assign now_sel   = decode(addr);
    assign wr_go     = wr_ev.fall & ~cs_n_s;
    assign rd_go     = rd_ev.fall & ~cs_n_s;
    assign cmd_start = wr_go & (now_sel == SEL_CMD);
    assign stat_rd   = rd_go & (now_sel == SEL_STATUS);
    assign cmd_commit = wr_ev.rise & wr_open & (wr_sel == SEL_CMD);
    assign sh_commit  = wr_ev.rise & wr_open & (wr_sel == SEL_SHARED);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_open <= 1'b0;
            wr_sel  <= SEL_NONE;
            wdata   <= '0;
        end else if (wr_go) begin
            wr_open <= 1'b1;
            wr_sel  <= now_sel;
            wdata   <= din;
        end else if (wr_ev.rise) begin
            wr_open <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            oe    <= 1'b0;
            rdata <= '0;
        end else if (rd_go) begin
            oe <= 1'b1;
            case (now_sel)
                SEL_CMD:    rdata <= cmd_q;
                SEL_STATUS: rdata <= stat_q;
                SEL_SHARED: rdata <= shared_q;
                default:    rdata <= '0;
            endcase
        end else if (rd_ev.rise) begin
            oe <= 1'b0;
        end
    end

endmodule

// File: rtl/mbox_bridge.sv
module mbox_bridge
    import mbox_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              m_cs_n,
    input  logic              m_rd_n,
    input  logic              m_wr_n,
    input  logic [3:0]        m_addr,
    inout  wire  [DATA_W-1:0] m_dbus,
    input  logic              s_cs_n,
    input  logic [3:0]        s_addr,
    input  logic [DATA_W-1:0] s_word,
    input  logic              s_ack,
    input  logic              s_irq_n,
    output logic [DATA_W-1:0] cmd_out,
    output logic              ready_out,
    output logic              irq_out
);
    logic [N_LINES-1:0] raw;
    edge_t              ev [N_LINES];

    assign raw[I_MCS]  = m_cs_n;
    assign raw[I_MRD]  = m_rd_n;
    assign raw[I_MWR]  = m_wr_n;
    assign raw[I_SCS]  = s_cs_n;
    assign raw[I_SACK] = s_ack;
    assign raw[I_SIRQ] = s_irq_n;

    for (genvar g = 0; g < N_LINES; g++) begin : g_sync
        mbox_sync_edge #(.STAGES(SYNC_STAGES), .IDLE_VAL(1'b1)) u_sync (
            .clk      (clk),
            .rst      (rst),
            .async_in (raw[g]),
            .ev       (ev[g])
        );
    end

    logic              cmd_start, cmd_commit, sh_commit, stat_rd, oe;
    logic [DATA_W-1:0] wdata, rdata, cmd_q, shared_q, stat_q;
    logic              ready_q, irq_q;
    logic              ack_rise, irq_fall, s_load, rd_lvl;

    assign stat_q   = {{(DATA_W-2){1'b0}}, irq_q, ready_q};
    assign ack_rise = ev[I_SACK].rise;
    assign irq_fall = ev[I_SIRQ].fall;
    assign s_load   = ev[I_SCS].fall & (s_addr == A_SLOAD);
    assign rd_lvl   = ev[I_MRD].lvl;

    mbox_host_if #(.DATA_W(DATA_W)) u_host (
        .clk        (clk),
        .rst        (rst),
        .cs_n_s     (ev[I_MCS].lvl),
        .wr_ev      (ev[I_MWR]),
        .rd_ev      (ev[I_MRD]),
        .addr       (m_addr),
        .din        (m_dbus),
        .cmd_q      (cmd_q),
        .stat_q     (stat_q),
        .shared_q   (shared_q),
        .cmd_start  (cmd_start),
        .cmd_commit (cmd_commit),
        .sh_commit  (sh_commit),
        .wdata      (wdata),
        .stat_rd    (stat_rd),
        .oe         (oe),
        .rdata      (rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ready_q  <= 1'b1;
            irq_q    <= 1'b0;
            cmd_q    <= '0;
            shared_q <= '0;
        end else begin
            if (cmd_start)     ready_q <= 1'b0;
            else if (ack_rise) ready_q <= 1'b1;

            if (irq_fall)     irq_q <= 1'b1;
            else if (stat_rd) irq_q <= 1'b0;

            if (cmd_commit) cmd_q <= wdata;

            if (sh_commit)   shared_q <= wdata;
            else if (s_load) shared_q <= s_word;
        end
    end

    assign m_dbus    = oe ? rdata : {DATA_W{1'bz}};
    assign cmd_out   = cmd_q;
    assign ready_out = ready_q;
    assign irq_out   = irq_q;

endmodule

// File: rtl/mbox_bridge_chk.sv
module mbox_bridge_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              ready_q,
    input logic              irq_q,
    input logic              oe,
    input logic              rd_lvl,
    input logic [DATA_W-1:0] cmd_q,
    input logic [DATA_W-1:0] shared_q,
    input logic [DATA_W-1:0] wdata,
    input logic              cmd_start,
    input logic              cmd_commit,
    input logic              sh_commit,
    input logic              s_load,
    input logic              ack_rise,
    input logic              irq_fall,
    input logic              stat_rd
);
    AST_CMD_LOAD:     assert property (@(posedge clk) disable iff (rst) cmd_commit |=> cmd_q == $past(wdata)); // R1
    AST_CMD_HOLD:     assert property (@(posedge clk) disable iff (rst) !$past(cmd_commit) |-> $stable(cmd_q)); // R1
    AST_BUSY_ON_CMD:  assert property (@(posedge clk) disable iff (rst) cmd_start |=> !ready_q); // R2
    AST_READY_EDGE:   assert property (@(posedge clk) disable iff (rst) $rose(ready_q) |-> $past(ack_rise)); // R3
    AST_IRQ_SET:      assert property (@(posedge clk) disable iff (rst) irq_fall |=> irq_q); // R4
    AST_IRQ_CLEAR:    assert property (@(posedge clk) disable iff (rst) (stat_rd && !irq_fall) |=> !irq_q); // R4
    AST_SHARED_HOLD:  assert property (@(posedge clk) disable iff (rst) !$past(sh_commit || s_load) |-> $stable(shared_q)); // R5
    AST_HOST_WINS:    assert property (@(posedge clk) disable iff (rst) (sh_commit && s_load) |=> shared_q == $past(wdata)); // R6
    AST_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (rst) oe |-> $past(!rd_lvl)); // R7
    AST_RESET_STATE:  assert property (@(posedge clk) rst |=> (ready_q && !irq_q && cmd_q == '0 && shared_q == '0)); // R8
endmodule

bind mbox_bridge mbox_bridge_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ready_q    (ready_q),
    .irq_q      (irq_q),
    .oe         (oe),
    .rd_lvl     (rd_lvl),
    .cmd_q      (cmd_q),
    .shared_q   (shared_q),
    .wdata      (wdata),
    .cmd_start  (cmd_start),
    .cmd_commit (cmd_commit),
    .sh_commit  (sh_commit),
    .s_load     (s_load),
    .ack_rise   (ack_rise),
    .irq_fall   (irq_fall),
    .stat_rd    (stat_rd)
);

// File: tb/mbox_bridge_test.sv
`timescale 1ns/1ps
module mbox_bridge_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       m_cs_n = 1'b1, m_rd_n = 1'b1, m_wr_n = 1'b1;
    logic [3:0] m_addr = 4'h0;
    logic       s_cs_n = 1'b1, s_ack = 1'b1, s_irq_n = 1'b1;
    logic [3:0] s_addr = 4'h0;
    logic [7:0] s_word = 8'h00;
    logic [7:0] cmd_out;
    logic       ready_out, irq_out;
    logic [7:0] drv = 8'h00;
    logic       drv_en = 1'b0;
    wire  [7:0] m_dbus;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [7:0] mdl_sh = 8'h00, mdl_cmd = 8'h00, rd_v;

    assign m_dbus = drv_en ? drv : 8'hzz;

    always #4 clk = ~clk;

    mbox_bridge uut (
        .clk(clk), .rst(rst), .m_cs_n(m_cs_n), .m_rd_n(m_rd_n), .m_wr_n(m_wr_n),
        .m_addr(m_addr), .m_dbus(m_dbus), .s_cs_n(s_cs_n), .s_addr(s_addr),
        .s_word(s_word), .s_ack(s_ack), .s_irq_n(s_irq_n), .cmd_out(cmd_out),
        .ready_out(ready_out), .irq_out(irq_out)
    );

    function automatic logic [7:0] exp_status(input logic irq, input logic rdy);
        return {6'b0, irq, rdy};
    endfunction

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [3:0] a, input logic [7:0] d, input logic sel_n);
        m_addr = a; drv = d; drv_en = 1'b1; m_cs_n = sel_n;
        wait_n(3);
        m_wr_n = 1'b0;
        wait_n(12);
        m_wr_n = 1'b1;
        wait_n(6);
        m_cs_n = 1'b1; drv_en = 1'b0;
        wait_n(2);
    endtask

    task automatic host_read(input logic [3:0] a, output logic [7:0] d);
        m_addr = a; drv_en = 1'b0; m_cs_n = 1'b0;
        wait_n(3);
        m_rd_n = 1'b0;
        wait_n(10);
        d = m_dbus;
        m_rd_n = 1'b1;
        wait_n(6);
        m_cs_n = 1'b1;
        wait_n(2);
    endtask

    task automatic slave_load(input logic [3:0] a, input logic [7:0] w);
        s_addr = a; s_word = w;
        wait_n(2);
        s_cs_n = 1'b0;
        wait_n(12);
        s_cs_n = 1'b1;
        wait_n(6);
    endtask

    task automatic slave_ack_cycle();
        s_ack = 1'b0;
        wait_n(12);
        check("R3 ack low keeps busy", {7'b0, ready_out}, 8'h00);
        s_ack = 1'b1;
        wait_n(8);
        check("R3 ack rise sets ready", {7'b0, ready_out}, 8'h01);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd2024);
        wait_n(5);
        rst = 1'b0;
        wait_n(4);

        // R8 reset state
        check("R8 ready", {7'b0, ready_out}, 8'h01);
        check("R8 irq", {7'b0, irq_out}, 8'h00);
        check("R8 cmd", cmd_out, 8'h00);
        host_read(4'b1111, rd_v);
        check("R8 shared", rd_v, 8'h00);

        // R7 idle bus not driven by bridge
        drv = 8'h5A; drv_en = 1'b1;
        wait_n(3);
        check("R7 idle bus released", m_dbus, 8'h5A);
        drv_en = 1'b0;

        // R1 R2 R3 command handshake
        host_write(4'b0000, 8'hA7, 1'b0);
        check("R1 command loaded", cmd_out, 8'hA7);
        check("R2 busy after command", {7'b0, ready_out}, 8'h00);
        mdl_cmd = 8'hA7;
        slave_ack_cycle();
        host_read(4'b0000, rd_v);
        check("R7 command readback", rd_v, 8'hA7);
        host_read(4'b1100, rd_v);
        check("R7 status readback", rd_v, exp_status(1'b0, 1'b1));

        // R4 interrupt set and clear
        s_irq_n = 1'b0;
        wait_n(8);
        check("R4 irq set", {7'b0, irq_out}, 8'h01);
        s_irq_n = 1'b1;
        host_read(4'b1100, rd_v);
        check("R4 status shows irq", rd_v, exp_status(1'b1, 1'b1));
        check("R4 irq cleared by status read", {7'b0, irq_out}, 8'h00);

        // R4 same-cycle set beats clear
        m_addr = 4'b1100; m_cs_n = 1'b0;
        wait_n(3);
        m_rd_n = 1'b0; s_irq_n = 1'b0;
        wait_n(10);
        m_rd_n = 1'b1;
        wait_n(6);
        m_cs_n = 1'b1; s_irq_n = 1'b1;
        wait_n(2);
        check("R4 set wins", {7'b0, irq_out}, 8'h01);
        host_read(4'b1100, rd_v);
        check("R4 cleared afterwards", {7'b0, irq_out}, 8'h00);

        // R6 same-cycle host write beats slave load
        m_addr = 4'b1111; drv = 8'hC3; drv_en = 1'b1; m_cs_n = 1'b0;
        s_addr = 4'b1011; s_word = 8'h3C;
        wait_n(3);
        m_wr_n = 1'b0;
        wait_n(12);
        m_wr_n = 1'b1; s_cs_n = 1'b0;
        wait_n(8);
        s_cs_n = 1'b1; m_cs_n = 1'b1; drv_en = 1'b0;
        wait_n(4);
        host_read(4'b1111, rd_v);
        check("R6 host wins conflict", rd_v, 8'hC3);
        mdl_sh = 8'hC3;

        // R6 slave load at other address ignored
        slave_load(4'b1010, 8'h99);
        host_read(4'b1111, rd_v);
        check("R6 wrong slave address ignored", rd_v, mdl_sh);

        // R9 late bus changes ignored
        m_addr = 4'b1111; drv = 8'h1E; drv_en = 1'b1; m_cs_n = 1'b0;
        wait_n(3);
        m_wr_n = 1'b0;
        wait_n(6);
        drv = 8'hE1; m_addr = 4'b0000;
        wait_n(6);
        m_wr_n = 1'b1;
        wait_n(6);
        m_cs_n = 1'b1; drv_en = 1'b0;
        wait_n(2);
        mdl_sh = 8'h1E;
        host_read(4'b1111, rd_v);
        check("R9 data captured at strobe start", rd_v, 8'h1E);
        check("R9 address captured at strobe start", cmd_out, mdl_cmd);

        // R10 strobes without chip select
        host_write(4'b1111, 8'h77, 1'b1);
        host_write(4'b0000, 8'h66, 1'b1);
        host_read(4'b1111, rd_v);
        check("R10 shared unchanged", rd_v, mdl_sh);
        check("R10 command unchanged", cmd_out, mdl_cmd);
        check("R10 ready unchanged", {7'b0, ready_out}, 8'h01);

        // R5 R6 R1 random traffic
        for (int i = 0; i < 24; i++) begin
            logic [7:0] v;
            int op;
            v  = 8'($urandom);
            op = int'($urandom % 3);
            if (op == 0) begin
                host_write(4'b1111, v, 1'b0);
                mdl_sh = v;
                host_read(4'b1111, rd_v);
                check("R5 host shared write", rd_v, mdl_sh);
            end else if (op == 1) begin
                slave_load(4'b1011, v);
                mdl_sh = v;
                host_read(4'b1111, rd_v);
                check("R6 slave shared load", rd_v, mdl_sh);
            end else begin
                host_write(4'b0000, v, 1'b0);
                mdl_cmd = v;
                check("R1 random command", cmd_out, mdl_cmd);
                check("R2 random busy", {7'b0, ready_out}, 8'h00);
                slave_ack_cycle();
            end
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule